// File: doc/BRIEF.md
# Display Stripe Streamer

The stripe streamer copies one 16-row band of a 128 x 64 monochrome picture from a local 256-byte buffer into a serial LCD controller. Each buffer byte is a vertical run of 8 pixels. The lower 128 bytes belong to the upper 8-row hardware page of the band, and the upper 128 bytes to the lower page. A stripe number n from 0 to 3 selects hardware pages 2n and 2n+1.

For each of the two pages, the block does three things:
- It selects the controller with an active-low chip select.
- With the command/data line low, it sends three command bytes: column high nibble 0x10, column low nibble 0x00, and page select 0xB0 OR page number.
- It raises the command/data line and streams the 128 buffer bytes for that page in address order.

Chip select goes high for one cycle between the two pages. The buffer is read through a synchronous read port, so the block issues each address one cycle before it loads the byte.

A sequencer with four states drives the transfer:
- `S_IDLE` moves to `S_CMD` on start.
- `S_CMD` moves to `S_DATA` after the third command byte.
- `S_DATA` moves to `S_GAP` after byte 128 of the first page, or to `S_IDLE` after byte 128 of the second page.
- `S_GAP` moves to `S_CMD` after one cycle.

A byte serialiser under the sequencer shifts every byte out most significant bit first. Each bit takes one cycle with the serial clock low and then one cycle with it high, so a byte takes 16 cycles.

Top module: `stripe_streamer`

## Requirements
- R1: After reset and whenever the block is idle, chip select is high (deasserted), the serial clock is low, and busy and done are low.
- R2: Each page starts with command bytes 0x10 then 0x00, sent with the command/data line low (0) and chip select low.
- R3: For stripe n, the third command byte of the first page is 0xB0 OR 2n, and that of the second page is 0xB0 OR (2n+1).
- R4: After the page select, the command/data line is high (1) for exactly 128 data bytes. Buffer addresses 0..127 go to the first page and 128..255 to the second page, in ascending order.
- R5: Each bit is presented for one cycle with the serial clock low and then held for one cycle with the serial clock high. Bits go out most significant bit first, with no idle cycles between the bytes of a group.
- R6: Between the two pages, chip select is high for exactly one cycle. Chip select is low whenever the serial clock is high.
- R7: Each buffer read strobe is issued exactly one cycle before the byte it returns is loaded into the shifter.
- R8: Done is high for exactly one cycle, in the cycle after the final high serial-clock phase of the second page. In that cycle chip select is already high and busy is low.
- R9: A start pulse while busy is ignored and does not change the transfer in progress.
- R10: Only the low two bits of the stripe input select the stripe. For example, input 0xE selects stripe 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a transfer when idle |
| stripe_i | input | 4 | Stripe number; low two bits used |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_addr_o | output | 8 | Buffer read address |
| buf_data_i | input | 8 | Buffer read data, valid one cycle after the strobe |
| spi_sck_o | output | 1 | Serial clock; the display samples on its rising edge |
| spi_mosi_o | output | 1 | Serial data |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_dc_o | output | 1 | Command (0) or data (1) select |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check these local rules:
- the serial data does not change while the clock is high;
- chip select stays low whenever the clock is high;
- chip select is high in the gap state and while idle;
- each read strobe is followed by a byte boundary of the shifter;
- done lasts a single cycle.

Only the bench scenarios can show the complete serial stream, because the whole transfer must be compared against an independent model. This covers:
- the byte values and their order;
- the page numbers derived from the stripe, including a masked index;
- the exact cycle of done;
- that start pulses during a transfer, and a start held across the done cycle, produce the right sequence of transfers.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CMD  = 2'd1,
        S_DATA = 2'd2,
        S_GAP  = 2'd3
    } seq_state_t;

    localparam logic [7:0] CMD_COL_HIGH = 8'h10;
    localparam logic [7:0] CMD_COL_LOW  = 8'h00;
    localparam logic [7:0] CMD_PAGE_SEL = 8'hB0;
    localparam int         CMD_COUNT    = 3;
endpackage

// File: rtl/stripe_ser.sv
module stripe_ser #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              pre_last_o,
    output logic              last_o
);
    localparam int PH_N = 2 * BYTE_W;
    localparam int PH_W = $clog2(PH_N);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);
    localparam logic [PH_W-1:0] PH_PRE  = PH_W'(PH_N - 2);

    logic              run;
    logic [PH_W-1:0]   phase;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= 1'b0;
            phase <= '0;
            shreg <= '0;
        end else if (load_i) begin
            run   <= 1'b1;
            phase <= '0;
            shreg <= byte_i;
        end else if (run) begin
            phase <= phase + 1'b1;
            if (phase[0])
                shreg <= shreg << 1;
            if (phase == PH_LAST)
                run <= 1'b0;
        end
    end

    always_comb begin
        sck_o      = run & phase[0];
        mosi_o     = run & shreg[BYTE_W-1];
        last_o     = run && (phase == PH_LAST);
        pre_last_o = run && (phase == PH_PRE);
    end

    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(mosi_o));

    // R5
    clk_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !sck_o);
endmodule

// File: rtl/stripe_seq.sv
module stripe_seq
    import stripe_pkg::*;
#(
    parameter int COLS   = 128,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2,
    parameter int IDX_W  = 4,
    localparam int COL_W  = $clog2(COLS),
    localparam int ADDR_W = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  stripe_i,
    input  logic              ser_last_i,
    input  logic              ser_pre_last_i,
    input  logic [BYTE_W-1:0] buf_data_i,
    output logic              ser_load_o,
    output logic [BYTE_W-1:0] ser_byte_o,
    output logic              buf_rd_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic              cs_n_o,
    output logic              dc_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS - 1);
    localparam logic [1:0]       CMD_MAX = 2'(CMD_COUNT - 1);
    localparam int               PAD_W   = BYTE_W - SEL_W - 1;

    seq_state_t       state, nxt;
    logic [SEL_W-1:0] stripe_q;
    logic             page_q;
    logic [1:0]       cmd_cnt;
    logic [COL_W-1:0] col;

    function automatic logic [BYTE_W-1:0] cmd_byte(input logic [1:0] k,
                                                   input logic [SEL_W-1:0] s,
                                                   input logic p);
        unique case (k)
            2'd0:    return CMD_COL_HIGH;
            2'd1:    return CMD_COL_LOW;
            default: return CMD_PAGE_SEL | {{PAD_W{1'b0}}, s, p};
        endcase
    endfunction

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            stripe_q <= '0;
            page_q   <= 1'b0;
            cmd_cnt  <= '0;
            col      <= '0;
            cs_n_o   <= 1'b1;
            dc_o     <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            state  <= nxt;
            done_o <= 1'b0;
            unique case (state)
                S_IDLE: if (start_i) begin
                    stripe_q <= stripe_i[SEL_W-1:0];
                    page_q   <= 1'b0;
                    cmd_cnt  <= '0;
                    cs_n_o   <= 1'b0;
                    dc_o     <= 1'b0;
                end
                S_CMD: if (ser_last_i) begin
                    if (cmd_cnt != CMD_MAX) begin
                        cmd_cnt <= cmd_cnt + 1'b1;
                    end else begin
                        dc_o <= 1'b1;
                        col  <= '0;
                    end
                end
                S_DATA: if (ser_last_i) begin
                    if (col != COL_MAX) begin
                        col <= col + 1'b1;
                    end else begin
                        cs_n_o <= 1'b1;
                        dc_o   <= 1'b0;
                        if (page_q) done_o <= 1'b1;
                        else        page_q <= 1'b1;
                    end
                end
                S_GAP: begin
                    cs_n_o  <= 1'b0;
                    cmd_cnt <= '0;
                end
                default: ;
            endcase
        end
    end

    // next state and combinational outputs
    always_comb begin
        nxt        = state;
        ser_load_o = 1'b0;
        ser_byte_o = CMD_COL_HIGH;
        buf_rd_o   = 1'b0;
        buf_addr_o = {page_q, col + 1'b1};
        busy_o     = (state != S_IDLE);
        unique case (state)
            S_IDLE: if (start_i) begin
                ser_load_o = 1'b1;
                nxt        = S_CMD;
            end
            S_CMD: begin
                buf_addr_o = {page_q, {COL_W{1'b0}}};
                buf_rd_o   = ser_pre_last_i && (cmd_cnt == CMD_MAX);
                if (ser_last_i) begin
                    ser_load_o = 1'b1;
                    if (cmd_cnt != CMD_MAX) begin
                        ser_byte_o = cmd_byte(cmd_cnt + 1'b1, stripe_q, page_q);
                    end else begin
                        ser_byte_o = buf_data_i;
                        nxt        = S_DATA;
                    end
                end
            end
            S_DATA: begin
                buf_rd_o = ser_pre_last_i && (col != COL_MAX);
                if (ser_last_i) begin
                    if (col != COL_MAX) begin
                        ser_load_o = 1'b1;
                        ser_byte_o = buf_data_i;
                    end else begin
                        nxt = page_q ? S_IDLE : S_GAP;
                    end
                end
            end
            S_GAP: begin
                ser_load_o = 1'b1;
                nxt        = S_CMD;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && cs_n_o));

    // R6
    gap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> (cs_n_o && !dc_o));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);

    // R7
    read_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> (ser_last_i && ser_load_o));

    // R10
    stripe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (stripe_q == SEL_W'($past(stripe_i))));
endmodule

// File: rtl/stripe_streamer.sv
module stripe_streamer #(
    parameter int COLS   = 128,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2,
    parameter int IDX_W  = 4,
    localparam int ADDR_W = $clog2(COLS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  stripe_i,
    output logic              buf_rd_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    input  logic [BYTE_W-1:0] buf_data_i,
    output logic              spi_sck_o,
    output logic              spi_mosi_o,
    output logic              spi_cs_n_o,
    output logic              spi_dc_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              ser_load;
    logic [BYTE_W-1:0] ser_byte;
    logic              ser_last;
    logic              ser_pre_last;

    stripe_seq #(
        .COLS   (COLS),
        .BYTE_W (BYTE_W),
        .SEL_W  (SEL_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .stripe_i       (stripe_i),
        .ser_last_i     (ser_last),
        .ser_pre_last_i (ser_pre_last),
        .buf_data_i     (buf_data_i),
        .ser_load_o     (ser_load),
        .ser_byte_o     (ser_byte),
        .buf_rd_o       (buf_rd_o),
        .buf_addr_o     (buf_addr_o),
        .cs_n_o         (spi_cs_n_o),
        .dc_o           (spi_dc_o),
        .busy_o         (busy_o),
        .done_o         (done_o)
    );

    stripe_ser #(
        .BYTE_W (BYTE_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ser_load),
        .byte_i     (ser_byte),
        .sck_o      (spi_sck_o),
        .mosi_o     (spi_mosi_o),
        .pre_last_o (ser_pre_last),
        .last_o     (ser_last)
    );

    // R6
    sck_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck_o |-> !spi_cs_n_o);
endmodule

// File: tb/tb_stripe_streamer.sv
module tb_stripe_streamer;
    typedef struct packed {
        logic       cs_n;
        logic       dc;
        logic       sck;
        logic       mosi;
        logic       busy;
        logic       done;
        logic [3:0] tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] stripe_i = '0;
    logic       buf_rd_o;
    logic [7:0] buf_addr_o;
    logic [7:0] buf_data_i = '0;
    logic       spi_sck_o, spi_mosi_o, spi_cs_n_o, spi_dc_o, busy_o, done_o;

    logic [7:0] mem [256];
    exp_t       exp_q [$];
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    string      scen = "R1";

    always #2.5 clk = ~clk;

    stripe_streamer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stripe_i   (stripe_i),
        .buf_rd_o   (buf_rd_o),
        .buf_addr_o (buf_addr_o),
        .buf_data_i (buf_data_i),
        .spi_sck_o  (spi_sck_o),
        .spi_mosi_o (spi_mosi_o),
        .spi_cs_n_o (spi_cs_n_o),
        .spi_dc_o   (spi_dc_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    // synchronous buffer: data one cycle after the strobe (R7)
    always @(posedge clk) if (buf_rd_o) buf_data_i <= mem[buf_addr_o];

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd6: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic exp_t mk(input logic cs_n, dc, sck, mosi, busy, done,
                                input logic [3:0] tag);
        exp_t e;
        e.cs_n = cs_n; e.dc = dc; e.sck = sck; e.mosi = mosi;
        e.busy = busy; e.done = done; e.tag = tag;
        return e;
    endfunction

    // R5: low phase then high phase per bit, MSB first
    task automatic push_byte(input logic [7:0] b, input logic dc, input logic [3:0] tag);
        for (int i = 7; i >= 0; i--) begin
            exp_q.push_back(mk(1'b0, dc, 1'b0, b[i], 1'b1, 1'b0, tag));
            exp_q.push_back(mk(1'b0, dc, 1'b1, b[i], 1'b1, 1'b0, tag));
        end
    endtask

    task automatic push_transfer(input int s);
        for (int p = 0; p < 2; p++) begin
            push_byte(8'h10, 1'b0, 4'd2);
            push_byte(8'h00, 1'b0, 4'd2);
            push_byte(8'hB0 | 8'(2 * s + p), 1'b0, 4'd3);
            for (int c = 0; c < 128; c++) push_byte(mem[p * 128 + c], 1'b1, 4'd4);
            if (p == 0) exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6));
        end
        exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8));
    endtask

    // reference model: accept start only when the modelled transfer is over (R9, R10)
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) exp_q.delete();
        else if (start_i && exp_q.size() == 0) push_transfer(int'(stripe_i[1:0]));
    end

    always @(negedge clk) begin
        exp_t e;
        logic [5:0] act, expv;
        if (exp_q.size() != 0) e = exp_q.pop_front();
        else e = mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1);
        act  = {spi_cs_n_o, spi_dc_o, spi_sck_o, spi_mosi_o, busy_o, done_o};
        expv = {e.cs_n, e.dc, e.sck, e.mosi, e.busy, e.done};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s (scenario %s) cyc %0d {cs_n,dc,sck,mosi,busy,done} actual %b expected %b",
                     tag_name(e.tag), scen, cycles, act, expv);
        end
    end

    always @(posedge clk) begin
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog (scenario %s) actual running expected finished", scen);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + seed) ^ (i >> 3));
        mem[0] = 8'hFF; mem[127] = 8'h00; mem[128] = 8'h80; mem[255] = 8'h01;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse(input logic [3:0] s);
        step(1);
        start_i = 1'b1; stripe_i = s;
        step(1);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        step(2);
        while (exp_q.size() != 0) step(1);
        step(3);
    endtask

    initial begin
        fill(0);
        // R1: reset state and idle
        step(5);
        rst_n = 1'b1;
        step(6);
        // R2 R3 R4 R5 R6 R7 R8: stripe 0
        scen = "R3"; pulse(4'd0); wait_idle();
        // stripe 3, other buffer contents
        fill(91); scen = "R4"; pulse(4'd3); wait_idle();
        // R10: upper index bits ignored, 0xE selects stripe 2
        fill(200); scen = "R10"; pulse(4'hE); wait_idle();
        // R9: start pulses during transfer, including around the page gap
        fill(17); scen = "R9"; pulse(4'd1);
        step(100); pulse(4'd3);
        step(1980); pulse(4'd2);
        step(30);  pulse(4'd0);
        wait_idle();
        // R8 R9: start held across the done cycle starts the next transfer
        fill(5); scen = "R8";
        step(1); start_i = 1'b1; stripe_i = 4'd1;
        step(50); stripe_i = 4'd2;
        step(4200); start_i = 1'b0;
        wait_idle();
        step(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule